// File: doc/BRIEF.md
# Fail-Safe Fault Error Counter

This block keeps the fault error count of a fail-safe supervisor. Each monitored fault source raises a one-cycle detection strobe. A two-bit impact setting goes with each strobe and says whether the fault drives the safety output, the reset output, both, or neither. A watchdog error counter reports, also as a strobe, when it reaches its maximum. A separate setting says whether that event drives the safety output. The block registers the safety and reset outputs. It raises the count once for every cycle in which a fault's impact asserts either output.

Software can pulse the safety and reset outputs directly, and it can read the count. These requests never move the count. Two limits are programmable: an intermediate value and a maximum value. The count saturates at the maximum. Reaching the intermediate value produces a one-cycle pulse. Reaching the maximum with deep fail-safe enabled raises a deep fail-safe request that stays set until power-on reset. With deep fail-safe disabled, counting and the intermediate pulse go on unchanged, and only the request is withheld. A clear strobe zeroes the count, but only in a cycle in which no fault is driving an output.

Top module: `fault_err_tracker`

## Requirements
- R1: After power-on reset (porRstN low), faultCount is 0 and safeOut, rstOut, interPulse and dfsReq are all 0.
- R2: Fault i uses impact bits faultImpact[2i+1:2i], where bit 2i selects the safety output and bit 2i+1 selects the reset output. A fault strobe with a non-zero impact asserts the selected outputs one cycle later and raises faultCount by exactly one. The count still rises by only one when both outputs, or several faults, fire in the same cycle.
- R3: swSafeReq and swRstReq assert safeOut and rstOut one cycle later and leave faultCount unchanged.
- R4: A fault strobe whose impact is 00 asserts no output and leaves faultCount unchanged.
- R5: wdMaxHit with wdImpactSafe=1 asserts safeOut one cycle later and raises faultCount by one. With wdImpactSafe=0 it does neither.
- R6: faultCount never exceeds maxVal. A counting event while faultCount >= maxVal leaves it unchanged.
- R7: interPulse is high for exactly one cycle when a counting event moves faultCount onto interVal. It does not repeat while the count stays there, and it behaves the same whatever dfsEnable is.
- R8: With dfsEnable=1, a counting event that leaves faultCount at or above maxVal sets dfsReq. dfsReq then stays 1 through clears and further events until power-on reset.
- R9: With dfsEnable=0, dfsReq is never set, while counting and R7 behave as usual.
- R10: clrReq sets faultCount to 0 in the next cycle when no counting event occurs in the same cycle. If a counting event occurs in that cycle, the clear is ignored and the count increments instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Asynchronous power-on reset, active low |
| faultEvt | input | NUM_FAULTS | Per-source fault detection strobes |
| faultImpact | input | 2*NUM_FAULTS | Per-source impact: bit 2i safety, bit 2i+1 reset |
| wdMaxHit | input | 1 | Watchdog error counter reached its maximum (strobe) |
| wdImpactSafe | input | 1 | Watchdog maximum asserts the safety output |
| swSafeReq | input | 1 | Software request for the safety output |
| swRstReq | input | 1 | Software request for the reset output |
| clrReq | input | 1 | Software clear of the count |
| dfsEnable | input | 1 | Deep fail-safe entry enabled |
| interVal | input | CNT_W | Intermediate count value |
| maxVal | input | CNT_W | Maximum (saturation) count value |
| safeOut | output | 1 | Safety output assertion |
| rstOut | output | 1 | Reset output assertion |
| faultCount | output | CNT_W | Current fault error count |
| interPulse | output | 1 | One-cycle pulse on reaching the intermediate value |
| dfsReq | output | 1 | Latched deep fail-safe entry request |

## Verification
Suppose the counting strobe were decoded wrongly, for example from software requests or from zero-impact faults. faultCount would then read off by one on the cycle after the offending stimulus, and the tests read it on that cycle. A broken saturation or clear priority shows on the first event at the maximum, or in the first cycle where a clear and a fault arrive together. A dfsReq latch that is broken, or one that ignores dfsEnable, shows either in the cycle the count reaches the maximum or when the request fails to survive a later clear. A misplaced intermediate comparison shows up as a missing or repeated interPulse around the step onto interVal.

// File: rtl/fault_err_pkg.sv
package fault_err_pkg;
  localparam int IMPACT_W = 2;
  localparam int IMP_SAFE_BIT = 0;
  localparam int IMP_RST_BIT = 1;

  typedef struct packed {
    logic inc;
    logic clr;
  } cntStrb_t;
endpackage

// File: rtl/fault_err_ctrl.sv
module fault_err_ctrl
  import fault_err_pkg::*;
#(
  parameter int NUM_FAULTS = 4
) (
  input  logic                           clk,
  input  logic                           porRstN,
  input  logic [NUM_FAULTS-1:0]          faultEvt,
  input  logic [IMPACT_W*NUM_FAULTS-1:0] faultImpact,
  input  logic                           wdMaxHit,
  input  logic                           wdImpactSafe,
  input  logic                           swSafeReq,
  input  logic                           swRstReq,
  input  logic                           clrReq,
  output cntStrb_t                       strb,
  output logic                           safeOut,
  output logic                           rstOut
);
  logic [NUM_FAULTS-1:0] safeHit;
  logic [NUM_FAULTS-1:0] rstHit;
  logic faultSafe;
  logic faultRst;

  // Per-source impact decode
  for (genvar gi = 0; gi < NUM_FAULTS; gi++) begin : g_decode
    assign safeHit[gi] = faultEvt[gi] & faultImpact[IMPACT_W*gi + IMP_SAFE_BIT];
    assign rstHit[gi]  = faultEvt[gi] & faultImpact[IMPACT_W*gi + IMP_RST_BIT];
  end

  always_comb begin
    faultSafe = (|safeHit) | (wdMaxHit & wdImpactSafe);
    faultRst  = |rstHit;
    strb.inc  = faultSafe | faultRst;
    strb.clr  = clrReq & ~strb.inc;
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      safeOut <= 1'b0;
      rstOut  <= 1'b0;
    end else begin
      safeOut <= faultSafe | swSafeReq;
      rstOut  <= faultRst | swRstReq;
    end
  end

  // R3
  sw_safe_drives_out_chk: assert property (@(posedge clk) disable iff (!porRstN)
    swSafeReq |=> safeOut);
  // R3
  sw_rst_drives_out_chk: assert property (@(posedge clk) disable iff (!porRstN)
    swRstReq |=> rstOut);
  // R4
  none_impact_silent_chk: assert property (@(posedge clk) disable iff (!porRstN)
    (faultImpact == '0 && !wdMaxHit && !swSafeReq && !swRstReq) |=> (!safeOut && !rstOut));
  // R5
  wd_impact_safe_chk: assert property (@(posedge clk) disable iff (!porRstN)
    (wdMaxHit && wdImpactSafe) |=> safeOut);
endmodule

// File: rtl/fault_err_dpath.sv
module fault_err_dpath
  import fault_err_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             porRstN,
  input  cntStrb_t         strb,
  input  logic             dfsEnable,
  input  logic [CNT_W-1:0] interVal,
  input  logic [CNT_W-1:0] maxVal,
  output logic [CNT_W-1:0] cnt,
  output logic             interPulse,
  output logic             dfsReq
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] satCnt;
  logic             atMax;

  always_comb begin
    atMax  = (cnt >= maxVal);
    satCnt = atMax ? cnt : cnt + CNT_ONE;
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      cnt        <= '0;
      interPulse <= 1'b0;
    end else begin
      interPulse <= strb.inc && (satCnt == interVal) && (cnt != interVal);
      if (strb.inc)      cnt <= satCnt;
      else if (strb.clr) cnt <= '0;
    end
  end

  // Sticky deep fail-safe request, cleared only by power-on reset
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN)                                   dfsReq <= 1'b0;
    else if (strb.inc && dfsEnable && satCnt >= maxVal) dfsReq <= 1'b1;
  end

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!porRstN)
    (strb.inc && cnt >= maxVal) |=> $stable(cnt));
  // R2
  single_step_chk: assert property (@(posedge clk) disable iff (!porRstN)
    strb.inc |=> (cnt == $past(cnt) || cnt == $past(cnt) + CNT_ONE));
  // R7
  inter_single_cycle_chk: assert property (@(posedge clk) disable iff (!porRstN)
    interPulse |=> !interPulse);
  // R8
  dfs_sticky_chk: assert property (@(posedge clk) disable iff (!porRstN)
    dfsReq |=> dfsReq);
  // R9
  dfs_needs_enable_chk: assert property (@(posedge clk) disable iff (!porRstN)
    (!dfsReq && !dfsEnable) |=> !dfsReq);
  // R10
  clear_zeroes_chk: assert property (@(posedge clk) disable iff (!porRstN)
    (strb.clr && !strb.inc) |=> (cnt == '0));
endmodule

// File: rtl/fault_err_tracker.sv
module fault_err_tracker
  import fault_err_pkg::*;
#(
  parameter int NUM_FAULTS = 4,
  parameter int CNT_W = 3
) (
  input  logic                           clk,
  input  logic                           porRstN,
  input  logic [NUM_FAULTS-1:0]          faultEvt,
  input  logic [IMPACT_W*NUM_FAULTS-1:0] faultImpact,
  input  logic                           wdMaxHit,
  input  logic                           wdImpactSafe,
  input  logic                           swSafeReq,
  input  logic                           swRstReq,
  input  logic                           clrReq,
  input  logic                           dfsEnable,
  input  logic [CNT_W-1:0]               interVal,
  input  logic [CNT_W-1:0]               maxVal,
  output logic                           safeOut,
  output logic                           rstOut,
  output logic [CNT_W-1:0]               faultCount,
  output logic                           interPulse,
  output logic                           dfsReq
);
  cntStrb_t strb;

  fault_err_ctrl #(.NUM_FAULTS(NUM_FAULTS)) ctrl_i (
    .clk(clk), .porRstN(porRstN), .faultEvt(faultEvt), .faultImpact(faultImpact),
    .wdMaxHit(wdMaxHit), .wdImpactSafe(wdImpactSafe), .swSafeReq(swSafeReq),
    .swRstReq(swRstReq), .clrReq(clrReq), .strb(strb), .safeOut(safeOut), .rstOut(rstOut)
  );

  fault_err_dpath #(.CNT_W(CNT_W)) dpath_i (
    .clk(clk), .porRstN(porRstN), .strb(strb), .dfsEnable(dfsEnable),
    .interVal(interVal), .maxVal(maxVal), .cnt(faultCount),
    .interPulse(interPulse), .dfsReq(dfsReq)
  );

  // R3
  sw_keeps_count_chk: assert property (@(posedge clk) disable iff (!porRstN)
    (faultEvt == '0 && !wdMaxHit && !clrReq) |=> $stable(faultCount));
endmodule

// File: tb/fault_err_tracker_tb_top.sv
module fault_err_tracker_tb_top;
  localparam int NF = 4;
  localparam int CW = 3;

  logic clk = 1'b0;
  logic porRstN = 1'b0;
  logic [NF-1:0] faultEvt = '0;
  logic [2*NF-1:0] faultImpact = '0;
  logic wdMaxHit = 1'b0, wdImpactSafe = 1'b0;
  logic swSafeReq = 1'b0, swRstReq = 1'b0, clrReq = 1'b0;
  logic dfsEnable = 1'b1;
  logic [CW-1:0] interVal = 3'd3, maxVal = 3'd6;
  logic safeOut, rstOut, interPulse, dfsReq;
  logic [CW-1:0] faultCount;

  int nTests = 0, nFail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fault_err_tracker #(.NUM_FAULTS(NF), .CNT_W(CW)) dut_i (
    .clk(clk), .porRstN(porRstN), .faultEvt(faultEvt), .faultImpact(faultImpact),
    .wdMaxHit(wdMaxHit), .wdImpactSafe(wdImpactSafe), .swSafeReq(swSafeReq),
    .swRstReq(swRstReq), .clrReq(clrReq), .dfsEnable(dfsEnable),
    .interVal(interVal), .maxVal(maxVal), .safeOut(safeOut), .rstOut(rstOut),
    .faultCount(faultCount), .interPulse(interPulse), .dfsReq(dfsReq)
  );

  task automatic check(string req, int act, int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive one cycle of stimulus, then sample at the following negedge
  task automatic cycle();
    @(negedge clk);
    faultEvt = '0; faultImpact = '0; wdMaxHit = 0; wdImpactSafe = 0;
    swSafeReq = 0; swRstReq = 0; clrReq = 0;
  endtask

  task automatic fault(int idx, logic [1:0] imp);
    faultEvt[idx] = 1'b1;
    faultImpact[2*idx +: 2] = imp;
    cycle();
  endtask

  task automatic doPor();
    porRstN = 1'b0;
    repeat (2) @(negedge clk);
    porRstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 count", faultCount, 0);
    check("R1 safeOut", safeOut, 0);
    check("R1 rstOut", rstOut, 0);
    check("R1 dfsReq", dfsReq, 0);
    check("R1 interPulse", interPulse, 0);
  endtask

  task automatic t_impact();
    fault(0, 2'b01);
    check("R2 safe impact out", {safeOut, rstOut}, 2);
    check("R2 count 1", faultCount, 1);
    fault(1, 2'b10);
    check("R2 rst impact out", {safeOut, rstOut}, 1);
    check("R2 count 2", faultCount, 2);
    faultEvt = 4'b1100; faultImpact = 8'b0111_0000;
    cycle();
    check("R2 both outputs", {safeOut, rstOut}, 3);
    check("R2 one step for joint event", faultCount, 3);
    check("R7 pulse on reaching 3", interPulse, 1);
    cycle();
    check("R7 pulse single cycle", interPulse, 0);
  endtask

  task automatic t_none();
    fault(2, 2'b00);
    check("R4 no output", {safeOut, rstOut}, 0);
    check("R4 count held", faultCount, 3);
  endtask

  task automatic t_sw();
    swSafeReq = 1; swRstReq = 1;
    cycle();
    check("R3 sw outputs", {safeOut, rstOut}, 3);
    check("R3 count held", faultCount, 3);
  endtask

  task automatic t_wd();
    wdMaxHit = 1; wdImpactSafe = 0;
    cycle();
    check("R5 wd no impact out", safeOut, 0);
    check("R5 wd no impact count", faultCount, 3);
    wdMaxHit = 1; wdImpactSafe = 1;
    cycle();
    check("R5 wd impact out", safeOut, 1);
    check("R5 wd impact count", faultCount, 4);
  endtask

  task automatic t_clear();
    clrReq = 1; faultEvt[3] = 1; faultImpact[7:6] = 2'b01;
    cycle();
    check("R10 clear ignored while pending", faultCount, 5);
    clrReq = 1;
    cycle();
    check("R10 clear zeroes", faultCount, 0);
  endtask

  task automatic t_nodfs();
    dfsEnable = 0;
    for (int k = 1; k <= 6; k++) begin
      fault(0, 2'b01);
      check("R9 counts while disabled", faultCount, k);
      check("R7 pulse with dfs off", interPulse, (k == 3) ? 1 : 0);
    end
    check("R9 no request", dfsReq, 0);
    fault(1, 2'b11);
    check("R6 saturates", faultCount, 6);
    check("R7 no repeat at max", interPulse, 0);
    check("R9 still no request", dfsReq, 0);
  endtask

  task automatic t_dfs();
    dfsEnable = 1;
    clrReq = 1;
    cycle();
    check("R10 clear", faultCount, 0);
    for (int k = 1; k <= 6; k++) begin
      fault(2, 2'b10);
      check("R8 request at max", dfsReq, (k == 6) ? 1 : 0);
    end
    clrReq = 1;
    cycle();
    check("R8 sticky across clear", dfsReq, 1);
    check("R10 count cleared", faultCount, 0);
    doPor();
    check("R8 released by por", dfsReq, 0);
    check("R1 count after por", faultCount, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    porRstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_impact();
    t_none();
    t_sw();
    t_wd();
    t_clear();
    t_nodfs();
    t_dfs();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule